// File: doc/BRIEF.md
# PHY Status-Change Interrupt Controller

This block gathers status-change events from a 10/100 Ethernet PHY core and turns them into one active-low interrupt request for the station manager. The events are auto-negotiation done, link state change, speed change and duplex change. Each arrives as a one-cycle pulse and is held in a status register until that register is read. A management front end, such as an MDIO slave, reaches the block through a small parallel register port. That port offers a combined enable/mask register, the event status register, and a sticky remote-fault register.

A status bit stays set from the cycle after its event until the next read of the status register. The read itself returns the held bits. An event that arrives in the same cycle as that read is not lost: it remains held after the read. The interrupt pin goes low only when the global enable bit is set and at least one held event has its mask bit set. Masked events are still recorded. The remote-fault bit records the OR of a locally detected fault and a fault reported by the link partner, and it clears only when its register is read.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, and reads of the enable/mask, status and fault registers all return 0.
- R2: A pulse on an event input sets its status bit on the next clock edge. The bit stays set until a status read. The status register is at address 1, with bit 0 auto-negotiation done, bit 1 link change, bit 2 speed change and bit 3 duplex change.
- R3: A read of the status register (reg_rd=1, address 1) returns the held bits in the same cycle and clears them at the clock edge that ends the read.
- R4: An event pulse that coincides with a status read is still held after that read.
- R5: An event is recorded even when its mask bit is 0, but a masked event never pulls `irq_n` low.
- R6: `irq_n` is 0 exactly when the global enable is set and some held event has its mask bit set. It follows the register state at the edge where that state changes.
- R7: While the global enable (bit 15 of the enable/mask register) is 0, `irq_n` stays 1 whatever events are held.
- R8: The fault register (address 2, bit 0) is set by either `fault_local` or `fault_partner`. It stays set until read and clears on the edge ending the read, unless a fault input is still high in that cycle.
- R9: Reserved bits read as 0. Writes to reserved bits, to the status and fault registers, and to unmapped addresses have no effect.
- R10: The enable/mask register (address 0; bits 3:0 are the mask bits in the same order as the status bits, bit 15 is the global enable) reads back the value last written to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; clears read-sensitive registers |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_an_done | input | 1 | Auto-negotiation finished pulse |
| evt_link_chg | input | 1 | Link state changed pulse |
| evt_speed_chg | input | 1 | Speed changed pulse |
| evt_duplex_chg | input | 1 | Duplex changed pulse |
| fault_local | input | 1 | Locally detected remote fault |
| fault_partner | input | 1 | Fault reported by link partner |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Read data is combinational, so it is sampled 1 ns after the falling edge that drives the read, before the edge that clears the register. Register updates, and the `irq_n` change that follows them, take effect at the next rising edge. The bench samples `irq_n` 1 ns after that edge. Each table row therefore checks the value read in the row's own cycle and the interrupt level after the row's clock edge. A same-cycle event and read is one row whose following row must still see the bit.

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
  parameter int ADDR_W     = 5,
  parameter int N_EVT      = 4,
  parameter int ADDR_CTRL  = 0,
  parameter int ADDR_STAT  = 1,
  parameter int ADDR_FAULT = 2,
  parameter int GIE_BIT    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              evt_an_done,
  input  logic              evt_link_chg,
  input  logic              evt_speed_chg,
  input  logic              evt_duplex_chg,
  input  logic              fault_local,
  input  logic              fault_partner,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_FAULT = ADDR_W'(ADDR_FAULT);

  logic [N_EVT-1:0] mask_q, stat_q, evt;
  logic             gie_q, fault_q;
  logic             wr_ctrl, rd_stat, rd_fault, fault_in;

  assign evt      = N_EVT'({evt_duplex_chg, evt_speed_chg, evt_link_chg, evt_an_done});
  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign rd_stat  = reg_rd && reg_addr == A_STAT;
  assign rd_fault = reg_rd && reg_addr == A_FAULT;
  assign fault_in = fault_local | fault_partner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      gie_q   <= 1'b0;
      stat_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mask_q <= reg_wdata[N_EVT-1:0];
        gie_q  <= reg_wdata[GIE_BIT];
      end
      stat_q  <= (rd_stat ? '0 : stat_q) | evt;
      fault_q <= (rd_fault ? 1'b0 : fault_q) | fault_in;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[N_EVT-1:0] = mask_q;
        reg_rdata[GIE_BIT]   = gie_q;
      end
      A_STAT:  reg_rdata[N_EVT-1:0] = stat_q;
      A_FAULT: reg_rdata[0] = fault_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_n = !(gie_q && |(stat_q & mask_q));

  p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
  p_stat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat && evt == '0) |=> $stable(stat_q));
  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && evt == '0) |=> (stat_q == '0));
  p_read_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && evt != '0) |=> (stat_q == $past(evt)));
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |-> irq_n);
  p_gie_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> irq_n);
  p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> fault_q);
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !rd_fault) |=> fault_q);
endmodule

// File: tb/test_phy_irq_ctrl.sv
module test_phy_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  evt = '0;
  logic        fl = 1'b0, fp = 1'b0;
  logic        irq_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  phy_irq_ctrl i_phy_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_an_done(evt[0]), .evt_link_chg(evt[1]), .evt_speed_chg(evt[2]),
    .evt_duplex_chg(evt[3]), .fault_local(fl), .fault_partner(fp), .irq_n(irq_n));

  typedef struct packed {
    logic [15:0] tag;
    logic        wr, rd;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [3:0]  evt;
    logic        fl, fp;
    logic [15:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{"R1",  1'b0,1'b1,5'd0,16'h0000,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R10", 1'b1,1'b0,5'd0,16'h800F,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R10", 1'b0,1'b1,5'd0,16'h0000,4'h0,1'b0,1'b0,16'h800F,1'b1},
    '{"R6",  1'b0,1'b0,5'd0,16'h0000,4'h2,1'b0,1'b0,16'h0000,1'b0},
    '{"R3",  1'b0,1'b1,5'd1,16'h0000,4'h0,1'b0,1'b0,16'h0002,1'b1},
    '{"R3",  1'b0,1'b1,5'd1,16'h0000,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R10", 1'b1,1'b0,5'd0,16'h8005,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R5",  1'b0,1'b0,5'd0,16'h0000,4'h8,1'b0,1'b0,16'h0000,1'b1},
    '{"R10", 1'b0,1'b1,5'd0,16'h0000,4'h0,1'b0,1'b0,16'h8005,1'b1},
    '{"R6",  1'b0,1'b0,5'd0,16'h0000,4'h4,1'b0,1'b0,16'h0000,1'b0},
    '{"R4",  1'b0,1'b1,5'd1,16'h0000,4'h1,1'b0,1'b0,16'h000C,1'b0},
    '{"R4",  1'b0,1'b1,5'd1,16'h0000,4'h0,1'b0,1'b0,16'h0001,1'b1},
    '{"R7",  1'b1,1'b0,5'd0,16'h000F,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R7",  1'b0,1'b0,5'd0,16'h0000,4'hF,1'b0,1'b0,16'h0000,1'b1},
    '{"R6",  1'b1,1'b0,5'd0,16'h800F,4'h0,1'b0,1'b0,16'h0000,1'b0},
    '{"R2",  1'b0,1'b1,5'd1,16'h0000,4'h0,1'b0,1'b0,16'h000F,1'b1},
    '{"R9",  1'b1,1'b0,5'd0,16'h7FF0,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R9",  1'b0,1'b1,5'd0,16'h0000,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R9",  1'b1,1'b0,5'd1,16'hFFFF,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R9",  1'b0,1'b1,5'd1,16'h0000,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R8",  1'b0,1'b0,5'd0,16'h0000,4'h0,1'b1,1'b0,16'h0000,1'b1},
    '{"R8",  1'b0,1'b1,5'd2,16'h0000,4'h0,1'b0,1'b0,16'h0001,1'b1},
    '{"R8",  1'b0,1'b1,5'd2,16'h0000,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R8",  1'b0,1'b0,5'd0,16'h0000,4'h0,1'b0,1'b1,16'h0000,1'b1},
    '{"R8",  1'b0,1'b1,5'd2,16'h0000,4'h0,1'b0,1'b1,16'h0001,1'b1},
    '{"R8",  1'b0,1'b1,5'd2,16'h0000,4'h0,1'b0,1'b0,16'h0001,1'b1},
    '{"R8",  1'b0,1'b1,5'd2,16'h0000,4'h0,1'b0,1'b0,16'h0000,1'b1},
    '{"R9",  1'b1,1'b1,5'd7,16'hFFFF,4'h0,1'b0,1'b0,16'h0000,1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [4:0] a, input logic [15:0] d,
                       input logic [3:0] e, input logic l, input logic p);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; evt = e; fl = l; fp = p;
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    drive(1'b0, 1'b0, a, 16'h0, 4'h0, 1'b0, 1'b0);
    #1 check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq_n == 1'b1, "R1", 16'(irq_n), 16'h1);
    rst_n = 1'b1;
    rd_expect(5'd0, 16'h0, "R1");
    rd_expect(5'd1, 16'h0, "R1");
    rd_expect(5'd2, 16'h0, "R1");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wdata, VEC[i].evt, VEC[i].fl, VEC[i].fp);
      #1;
      if (VEC[i].rd)
        check(reg_rdata == VEC[i].exp_rd, string'(VEC[i].tag), reg_rdata, VEC[i].exp_rd);
      @(posedge clk);
      #1 check(irq_n == VEC[i].exp_irq, string'(VEC[i].tag), 16'(irq_n), 16'(VEC[i].exp_irq));
    end

    // R2: bit stays held across idle cycles until read
    @(negedge clk);
    drive(1'b1, 1'b0, 5'd0, 16'h800F, 4'h8, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 5'd0, 16'h0, 4'h0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(irq_n == 1'b0, "R2", 16'(irq_n), 16'h0);
    rd_expect(5'd1, 16'h0008, "R2");

    // R1: reset mid-run clears everything
    @(negedge clk);
    drive(1'b0, 1'b0, 5'd0, 16'h0, 4'h0, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 5'd0, 16'h0, 4'h0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1 check(irq_n == 1'b1, "R1", 16'(irq_n), 16'h1);
    @(negedge clk);
    rst_n = 1'b1;
    rd_expect(5'd0, 16'h0, "R1");
    rd_expect(5'd1, 16'h0, "R1");
    rd_expect(5'd2, 16'h0, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule